// File: doc/BRIEF.md
# Constant Tripler Built From Ripple Cells

This block multiplies an unsigned operand of parameterized width by three. It is purely combinational. It contains no adder tree and no shift-and-add path. Instead, a row of identical one-bit cells runs from the least significant bit upward. Each cell adds three times its own operand bit to the carry it receives from the cell below. It keeps the low bit of that total as its result bit and passes the rest upward as a carry. That carry is 0, 1 or 2, so it needs two wires between neighbouring cells.

The carry chain starts at zero. The two carry wires leaving the most significant cell become the two top bits of the product, which makes the result exactly two bits wider than the operand. The cell equations are minimized sum-of-products expressions. They treat the unused carry code as a don't-care.

Top module: `tripler`

## Requirements
- R1: With an operand of WIDTH bits, the output is WIDTH+2 bits wide and equals exactly three times the operand, as an unsigned value, for every operand value.
- R2: Each cell's result bit is the low bit of (3 × operand bit + incoming carry value). In particular, output bit 0 always equals operand bit 0.
- R3: Each cell's outgoing carry value is the integer half, rounded down, of (3 × operand bit + incoming carry value). So the carry into bit 1 equals operand bit 0, and output bit 1 equals operand bit 1 XOR operand bit 0.
- R4: A carry travels on two wires as {hi, lo}: 00 stands for zero, 01 for one and 10 for two.
- R5: The lowest cell receives carry code 00, so an all-zero operand gives an all-zero output.
- R6: The carry code 11 never occurs on any link between cells, nor on the top two output bits.
- R7: Output bit WIDTH carries the lo wire of the top cell's outgoing carry, and output bit WIDTH+1 carries the hi wire. An all-ones operand gives code 10 on these two bits. An operand with only its top bit set gives code 01.
- R8: The operand width is a parameter. The block gives correct products at both WIDTH=4 and WIDTH=8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | Unsigned operand |
| y_o | output | WIDTH+2 | Product, three times x_i |

## Verification
The internal carry links are the hardest thing to reach from the ports. Only the top link is visible, as the top two output bits. The carry code of 10 must ripple through long runs of ones before it shows there. The stimulus therefore sweeps every operand value at both widths, so every cell sees every reachable combination of operand bit and incoming carry. The assertions inside each cell watch the hidden links, while the bench checks the top link directly for code 11 and for the expected codes on the all-ones and top-bit-only operands.

// File: rtl/tripler_pkg.sv
package tripler_pkg;

    // Two-wire carry between cells: {hi, lo}
    typedef enum logic [1:0] {
        CARRY_ZERO = 2'b00,
        CARRY_ONE  = 2'b01,
        CARRY_TWO  = 2'b10
    } carry_e;

    typedef struct packed {
        carry_e carry;
        logic   sum;
    } cell_out_t;

    // Numeric weight of a carry code
    function automatic int unsigned carry_weight(input logic [1:0] code);
        return 32'(code);
    endfunction

endpackage

// File: rtl/tripler_cell.sv
module tripler_cell
    import tripler_pkg::*;
(
    input  logic      x_i,
    input  carry_e    cin_i,
    output cell_out_t out_o
);

    logic c_hi, c_lo;
    logic s, co_hi, co_lo;

    assign c_hi = cin_i[1];
    assign c_lo = cin_i[0];

    // Minimized sum-of-products; input code 11 treated as don't-care
    always_comb begin
        s     = (x_i & ~c_lo) | (~x_i & c_lo);
        co_lo = (~x_i & c_hi) | (x_i & ~c_hi & ~c_lo);
        co_hi = (x_i & c_lo) | (x_i & c_hi);
    end

    assign out_o.sum   = s;
    assign out_o.carry = carry_e'({co_hi, co_lo});

    always_comb begin
        // R6
        cin_legal_chk: assert (cin_i !== 2'b11)
            else $error("carry-in code 11 reached a cell");
        // R6
        cout_legal_chk: assert (out_o.carry !== 2'b11)
            else $error("carry-out code 11 left a cell");
        // R2 R3
        if (!$isunknown({x_i, cin_i}) && cin_i != 2'b11) begin
            cell_arith_chk: assert (2 * carry_weight(out_o.carry) + 32'(out_o.sum)
                                    == 3 * 32'(x_i) + carry_weight(cin_i))
                else $error("cell total mismatch");
        end
    end

endmodule

// File: rtl/tripler_chain.sv
module tripler_chain
    import tripler_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    output logic [WIDTH-1:0] sum_o,
    output carry_e           carry_o
);

    carry_e    link [WIDTH:0];
    cell_out_t cell_out [WIDTH];

    // R5
    assign link[0] = CARRY_ZERO;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        tripler_cell u_cell (
            .x_i   (x_i[i]),
            .cin_i (link[i]),
            .out_o (cell_out[i])
        );
        assign sum_o[i]  = cell_out[i].sum;
        assign link[i+1] = cell_out[i].carry;
    end

    assign carry_o = link[WIDTH];

endmodule

// File: rtl/tripler.sv
module tripler
    import tripler_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    output logic [WIDTH+1:0] y_o
);

    localparam int unsigned OUT_W = WIDTH + 2;

    logic [WIDTH-1:0] sum;
    carry_e           top_carry;

    tripler_chain #(.WIDTH(WIDTH)) u_chain (
        .x_i     (x_i),
        .sum_o   (sum),
        .carry_o (top_carry)
    );

    // R7: lo wire to bit WIDTH, hi wire to bit WIDTH+1
    assign y_o = {top_carry[1], top_carry[0], sum};

    always_comb begin
        if (!$isunknown(x_i)) begin
            // R1
            product_chk: assert (y_o == OUT_W'(3) * {2'b00, x_i})
                else $error("product differs from three times operand");
            // R6
            top_code_chk: assert (y_o[OUT_W-1:WIDTH] != 2'b11)
                else $error("top carry code 11");
            // R2
            lsb_pass_chk: assert (y_o[0] == x_i[0])
                else $error("bit 0 differs from operand bit 0");
        end
    end

endmodule

// File: tb/test_tripler.sv
module test_tripler;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [7:0] x8 = '0;
    logic [9:0] y8;
    logic [3:0] x4 = '0;
    logic [5:0] y4;

    tripler #(.WIDTH(8)) i_tripler    (.x_i(x8), .y_o(y8));
    tripler #(.WIDTH(4)) i_tripler_w4 (.x_i(x4), .y_o(y4));

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int x8_q[$];
    int x4_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_one(input int w, input int xv, input int yv);
        int mask;
        int top;
        mask = (1 << w) - 1;
        top  = (yv >> w) & 3;
        check(yv == 3 * xv, "R1/R8 product", yv, 3 * xv);
        check((yv & 1) == (xv & 1), "R2 bit0", yv & 1, xv & 1);
        check(((yv >> 1) & 1) == (((xv >> 1) ^ xv) & 1), "R3 bit1",
              (yv >> 1) & 1, ((xv >> 1) ^ xv) & 1);
        check(top != 3, "R6 top code", top, 0);
        if (xv == 0) check(yv == 0, "R5 zero", yv, 0);
        if (xv == mask) check(top == 2, "R4/R7 all ones top code", top, 2);
        if (xv == (1 << (w - 1))) check(top == 1, "R7 msb only top code", top, 1);
    endtask

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        if (x8_q.size() > 0) check_one(8, x8_q.pop_front(), int'(y8));
        if (x4_q.size() > 0) check_one(4, x4_q.pop_front(), int'(y4));
    end

    initial begin
        check($bits(y8) == 10, "R8 width 8", $bits(y8), 10);
        check($bits(y4) == 6,  "R8 width 4", $bits(y4), 6);
        for (int v = 0; v < 256; v++) begin
            @(posedge clk);
            #1;
            x8 = v[7:0];
            x8_q.push_back(v);
            if (v < 16) begin
                x4 = v[3:0];
                x4_q.push_back(v);
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule